// File: doc/BRIEF.md
# Staged PLL Configuration Register Bank

This block sits on a host control bus and watches 32-bit command words. Writes aimed at an eight-address window of synthesizer setup registers are captured in a set of shadow registers. The programming outputs driven to the downstream serial PLL programmer do not change while the host fills these registers one by one. The whole configuration moves to the active set in one clock edge, and only when the host writes the last address of the window. A single-cycle strobe then tells the programmer to shift the new settings out.

The window holds two groups. The four lower addresses belong to the IF side of the synthesizer, which is unconnected in practice. The four upper addresses belong to the RF side and hold two reference-divider words followed by two feedback-divider words. The registers cannot be read back. Any command other than a write, and any address outside the window, is ignored.

Top module: `pll_cfg_bank`

## Requirements
- R1: A command word is split as follows: bits 31..28 hold the command code, bits 27..16 hold the address, and bits 15..0 hold a 16-bit register value (high byte in bits 15..8, low byte in bits 7..0).
- R2: The block accepts a word only when the command code is 0x1 (write). Any other code changes no register and raises no strobe.
- R3: The window covers addresses 0x802 to 0x809. A write to an address outside it (for example 0x801, 0x80A or 0x000) changes no register and raises no strobe.
- R4: A write to any address from 0x802 to 0x808 updates only that address's shadow value. The active outputs and the strobe stay unchanged.
- R5: A write to 0x809 copies all eight values to the active set on the same clock edge. Addresses 0x802..0x808 take their shadow values and 0x809 takes the incoming data. The value for address 0x802+i appears on active_regs_o[16*i+15:16*i] in the cycle after that edge.
- R6: config_update_o is high for exactly the one cycle that follows each commit edge, and low at all other times.
- R7: While rst_ni is low, all shadow and active values are zero and config_update_o is low.
- R8: Shadow values are kept after a commit. A later write to 0x809 alone commits the earlier values of 0x802..0x808 together with the new value of 0x809.
- R9: A word presented while cmd_valid_i is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command word present this cycle |
| cmd_word_i | input | 32 | Command word: code, address, data |
| active_regs_o | output | 128 | Active register values, address 0x802+i at slice i |
| config_update_o | output | 1 | One-cycle strobe after each commit |

## Verification
The embedded assertions check on every cycle that rejected or invalid words never produce a shadow write. They also check that a shadow slot changes only when it is addressed, that the active bus holds still unless a commit occurs, that every commit is followed by the strobe, and that the strobe never appears without one. Only the bench scenarios can show that the right values land in the right output slices. The same applies to the exact field split and window edges of the command word, the retention of shadow values across a second commit, and the reset contents seen at the ports.

// File: rtl/pll_cfg_pkg.sv
`timescale 1ns/1ps
package pll_cfg_pkg;
  localparam int CMD_W  = 4;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam logic [CMD_W-1:0] CMD_WRITE = 4'h1;

  // R1: field split of a bus word
  typedef struct packed {
    logic [CMD_W-1:0]  code;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_word_t;
endpackage

// File: rtl/pll_cmd_decode.sv
`timescale 1ns/1ps
module pll_cmd_decode
  import pll_cfg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h802,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       word_i,
  output logic              we_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] data_o,
  output logic              commit_o
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_REGS);
  localparam logic [IDX_W-1:0]  LAST = IDX_W'(NUM_REGS - 1);

  cmd_word_t         w;
  logic [ADDR_W-1:0] offset;
  logic              in_win;

  assign w      = cmd_word_t'(word_i);
  // wrap-around makes addresses below the base fall outside as well
  assign offset = w.addr - BASE_ADDR;
  assign in_win = offset < SPAN;

  assign we_o     = valid_i && (w.code == CMD_WRITE) && in_win;
  assign idx_o    = offset[IDX_W-1:0];
  assign data_o   = w.data;
  assign commit_o = we_o && (idx_o == LAST);

  // R2
  wrong_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w.code != CMD_WRITE) |-> !we_o);
  // R9
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !(we_o || commit_o));
endmodule

// File: rtl/pll_shadow_bank.sv
`timescale 1ns/1ps
module pll_shadow_bank
  import pll_cfg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int IDX_W = $clog2(NUM_REGS),
  localparam int NSH   = NUM_REGS - 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [DATA_W-1:0]     data_i,
  output logic [NSH*DATA_W-1:0] shadow_o
);
  // the last slot needs no shadow: its data is committed straight from the bus
  logic [DATA_W-1:0] regs_q [NSH];

  for (genvar i = 0; i < NSH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs_q[i] <= '0;
      else if (we_i && idx_i == IDX_W'(i))       regs_q[i] <= data_i;
    end
    assign shadow_o[i*DATA_W +: DATA_W] = regs_q[i];

    // R4
    slot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && idx_i == IDX_W'(i)) |=> $stable(shadow_o[i*DATA_W +: DATA_W]));
  end
endmodule

// File: rtl/pll_active_bank.sv
`timescale 1ns/1ps
module pll_active_bank
  import pll_cfg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int NSH = NUM_REGS - 1,
  localparam int TOT = NUM_REGS * DATA_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  commit_i,
  input  logic [DATA_W-1:0]     last_data_i,
  input  logic [NSH*DATA_W-1:0] shadow_i,
  output logic [TOT-1:0]        active_o,
  output logic                  update_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= '0;
      update_o <= 1'b0;
    end else begin
      update_o <= commit_i;
      if (commit_i) active_o <= {last_data_i, shadow_i};
    end
  end

  // R5
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(active_o));
  // R5
  last_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> active_o[TOT-1 -: DATA_W] == $past(last_data_i));
  // R6
  strobe_after_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> update_o);
  // R6
  no_stray_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> !update_o);
endmodule

// File: rtl/pll_cfg_bank.sv
`timescale 1ns/1ps
module pll_cfg_bank
  import pll_cfg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h802,
  localparam int IDX_W = $clog2(NUM_REGS),
  localparam int NSH   = NUM_REGS - 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cmd_valid_i,
  input  logic [31:0]                cmd_word_i,
  output logic [NUM_REGS*DATA_W-1:0] active_regs_o,
  output logic                       config_update_o
);
  logic                  we, commit;
  logic [IDX_W-1:0]      idx;
  logic [DATA_W-1:0]     data;
  logic [NSH*DATA_W-1:0] shadow;

  pll_cmd_decode #(.NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)) u_dec (
    .clk_i, .rst_ni,
    .valid_i(cmd_valid_i), .word_i(cmd_word_i),
    .we_o(we), .idx_o(idx), .data_o(data), .commit_o(commit)
  );

  pll_shadow_bank #(.NUM_REGS(NUM_REGS)) u_shadow (
    .clk_i, .rst_ni,
    .we_i(we), .idx_i(idx), .data_i(data), .shadow_o(shadow)
  );

  pll_active_bank #(.NUM_REGS(NUM_REGS)) u_active (
    .clk_i, .rst_ni,
    .commit_i(commit), .last_data_i(data), .shadow_i(shadow),
    .active_o(active_regs_o), .update_o(config_update_o)
  );

  // R7
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (active_regs_o == '0 && !config_update_o) || rst_ni);
endmodule

// File: tb/sim_pll_cfg_bank.sv
`timescale 1ns/1ps
module sim_pll_cfg_bank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         vld = 1'b0;
  logic [31:0]  word = '0;
  logic [127:0] act;
  logic         upd;
  int           total = 0, bad = 0;
  logic [15:0]  sh [8];
  logic [15:0]  ac [8];

  always #2 clk = ~clk;

  pll_cfg_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(vld), .cmd_word_i(word),
    .active_regs_o(act), .config_update_o(upd)
  );

  function automatic logic [127:0] exp_vec();
    logic [127:0] v;
    for (int i = 0; i < 8; i++) v[i*16 +: 16] = ac[i];
    return v;
  endfunction

  task automatic check(string req, logic [127:0] got, logic [127:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // drives one word for a cycle, updates the model, checks after the edge
  task automatic send(string req, logic v, logic [3:0] c, logic [11:0] a, logic [15:0] d);
    logic commit;
    commit = 1'b0;
    @(negedge clk);
    vld = v; word = {c, a, d};
    @(negedge clk);
    vld = 1'b0; word = '0;
    if (v && c == 4'h1 && a >= 12'h802 && a <= 12'h809) begin
      if (a == 12'h809) begin
        commit = 1'b1;
        for (int i = 0; i < 7; i++) ac[i] = sh[i];
        ac[7] = d;
      end else sh[a - 12'h802] = d;
    end
    check(req, act, exp_vec());
    check(req, {127'd0, upd}, {127'd0, commit});
    if (commit) begin
      @(negedge clk);
      check({req, " R6 strobe drop"}, {127'd0, upd}, 128'd0);
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) begin sh[i] = '0; ac[i] = '0; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 active", act, '0);
    check("R7 strobe", {127'd0, upd}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    send("R7 zero commit", 1'b1, 4'h1, 12'h809, 16'h0000);
  endtask

  task automatic t_fill_no_commit();
    for (int i = 0; i < 7; i++)
      send("R4 partial", 1'b1, 4'h1, 12'(12'h802 + i), 16'(16'hA100 + i * 16'h0111));
  endtask

  task automatic t_commit();
    send("R5 commit", 1'b1, 4'h1, 12'h809, 16'h5AC3);
    check("R1 byte split", {112'd0, act[127:112]}, {112'd0, 8'h5A, 8'hC3});
    check("R5 slot0", {112'd0, act[15:0]}, {112'd0, 16'hA100});
  endtask

  task automatic t_bad_code();
    send("R2 code0", 1'b1, 4'h0, 12'h803, 16'hDEAD);
    send("R2 code2", 1'b1, 4'h2, 12'h809, 16'hBEEF);
    send("R2 codeF", 1'b1, 4'hF, 12'h809, 16'h1234);
    send("R8 shadow kept", 1'b1, 4'h1, 12'h809, 16'h0F0F);
  endtask

  task automatic t_window();
    send("R3 below", 1'b1, 4'h1, 12'h801, 16'h1111);
    send("R3 above", 1'b1, 4'h1, 12'h80A, 16'h2222);
    send("R3 zero", 1'b1, 4'h1, 12'h000, 16'h3333);
    send("R3 far", 1'b1, 4'h1, 12'hF09, 16'h4444);
    send("R3 edge lo", 1'b1, 4'h1, 12'h802, 16'h7777);
    send("R3 commit", 1'b1, 4'h1, 12'h809, 16'h8888);
  endtask

  task automatic t_invalid();
    send("R9 idle", 1'b0, 4'h1, 12'h809, 16'h9999);
    send("R9 idle wr", 1'b0, 4'h1, 12'h805, 16'h9999);
    send("R9 commit", 1'b1, 4'h1, 12'h809, 16'hCAFE);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    vld = 1'b1; word = {4'h1, 12'h809, 16'h0001};
    @(negedge clk);
    check("R6 first", {127'd0, upd}, 128'd1);
    word = {4'h1, 12'h809, 16'h0002};
    @(negedge clk);
    vld = 1'b0; word = '0;
    check("R6 second", {127'd0, upd}, 128'd1);
    ac[7] = 16'h0002;
    check("R5 second value", act, exp_vec());
    @(negedge clk);
    check("R6 end", {127'd0, upd}, 128'd0);
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_fill_no_commit();
    t_commit();
    t_bad_code();
    t_window();
    t_invalid();
    t_back_to_back();
    t_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule